// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block runs a batch of analog-to-digital conversions over four input channels. A host sends three bytes on a simple byte interface: the convert command, a byte that picks which channels take part, and a byte that holds a two-bit preset code for each channel. The block first applies each selected channel's preset to its result word. It then asks an external converter for one conversion at a time. It always starts with the lowest selected channel and skips the channels that are not selected.

The converter is reached through a start pulse with a channel number. It answers with a one-cycle done strobe and a 16-bit result. Each result is stored in a byte-addressed result page that the host can read at any time. A busy flag covers the whole batch, and a one-cycle done pulse marks its end.

Top module: `cnvseq_top`

## Requirements
- R1: In idle, a byte of value 0x3C arms the block and any other byte is ignored. The next byte is the channel-select byte, and the byte after it is the preset byte. `busy` rises in the cycle after the preset byte is accepted.
- R2: Bit i of the select byte (bit 0 = channel A through bit 3 = channel D) set to 1 includes channel i in the batch.
- R3: The block gives exactly one `cnv_start` pulse per selected channel. Channels are started in ascending index order (A, B, C, D), unselected ones are skipped, and `cnv_chan` carries the index during the pulse.
- R4: Bits [2i+1:2i] of the preset byte hold the code for channel i, with the upper bit as the "set" flag and the lower bit as the "clear" flag. Code 01 presets the channel's result word to 0x0000, code 10 presets it to 0xFFFF, and code 00 keeps the previous value.
- R5: Code 11 behaves as 00. The word is kept and the channel is still converted.
- R6: Presets for all selected channels take effect in the cycle after `busy` rises, before the first conversion completes. Preset codes of unselected channels have no effect.
- R7: A `cnv_done` strobe while a conversion is outstanding stores `cnv_result` into channel i's word: the low byte at address 2i and the high byte at address 2i+1. A `cnv_done` at any other time is ignored.
- R8: Reset clears every result byte to zero and holds `busy`, `done` and `cnv_start` low.
- R9: `busy` stays high until the last selected result is stored. `done` is then high for exactly one cycle, and that is the first cycle in which `busy` is low.
- R10: A select byte of zero keeps `busy` high for one cycle and then gives `done`. It produces no `cnv_start` and leaves every result unchanged.
- R11: Bytes that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | Byte strobe from the host |
| byte_data | input | 8 | Command, select or preset byte |
| rd_addr | input | 3 | Result page byte address |
| rd_data | output | 8 | Result page byte (combinational read) |
| cnv_start | output | 1 | One-cycle request to the converter |
| cnv_chan | output | 2 | Channel index for the request |
| cnv_done | input | 1 | Converter result strobe |
| cnv_result | input | 16 | Converter result value |
| busy | output | 1 | Batch in progress |
| done | output | 1 | One-cycle end-of-batch pulse |

## Verification
The bench builds the block with its default four channels and 16-bit results. It drives a converter model whose latency it switches between 2 and 6 cycles. With the short latency, back-to-back starts and stores happen in adjacent cycles. With the long latency, there is a window in which preset values, and bytes that arrive while busy, can be observed before any result lands. The four channels allow every preset code and gapped select patterns such as B+D and A+C.

// File: rtl/cnvseq_pkg.sv
`timescale 1ns/1ps
package cnvseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_PRE,
        ST_PRESET,
        ST_START,
        ST_WAIT
    } seq_state_e;

    localparam logic [1:0] PRE_KEEP = 2'b00;
    localparam logic [1:0] PRE_ZERO = 2'b01;
    localparam logic [1:0] PRE_ONES = 2'b10;
    localparam logic [1:0] PRE_BAD  = 2'b11;

    localparam logic [7:0] CMD_CONVERT = 8'h3C;
endpackage

// File: rtl/cnvseq_pick.sv
`timescale 1ns/1ps
module cnvseq_pick #(
    parameter int NUM_CH = 4,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] mask,
    output logic [CH_W-1:0]   idx,
    output logic              any
);
    // lowest set bit wins: fixed ascending channel order
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx = CH_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cnvseq_page.sv
`timescale 1ns/1ps
module cnvseq_page
    import cnvseq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int RES_W  = 16,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int NBYTES = NUM_CH * RES_W / 8,
    localparam int ADDR_W = $clog2(NBYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pre_en,
    input  logic [NUM_CH-1:0]     pre_mask,
    input  logic [2*NUM_CH-1:0]   pre_codes,
    input  logic                  wr_en,
    input  logic [CH_W-1:0]       wr_ch,
    input  logic [RES_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [7:0]            rd_data
);
    logic [NUM_CH*RES_W-1:0] flat;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_word
        logic [RES_W-1:0] word_d, word_q;
        logic [1:0]       code;

        assign code = pre_codes[2*g +: 2];

        always_comb begin
            word_d = word_q;
            if (pre_en && pre_mask[g]) begin
                case (code)
                    PRE_ZERO: word_d = '0;
                    PRE_ONES: word_d = '1;
                    default:  word_d = word_q;
                endcase
            end
            if (wr_en && (wr_ch == CH_W'(g))) begin
                word_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign flat[g*RES_W +: RES_W] = word_q;

        // R4
        preset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_en && pre_mask[g] && code == PRE_ZERO) |=> (word_q == '0));
        // R4
        preset_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_en && pre_mask[g] && code == PRE_ONES) |=> (word_q == '1));
        // R5
        bad_code_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_en && pre_mask[g] && code == PRE_BAD) |=> $stable(word_q));
        // R7
        store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_ch == CH_W'(g)) |=> (word_q == $past(wr_data)));
    end

    assign rd_data = flat[{rd_addr, 3'b000} +: 8];
endmodule

// File: rtl/cnvseq_top.sv
`timescale 1ns/1ps
module cnvseq_top
    import cnvseq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int RES_W  = 16,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int NBYTES = NUM_CH * RES_W / 8,
    localparam int ADDR_W = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              cnv_start,
    output logic [CH_W-1:0]   cnv_chan,
    input  logic              cnv_done,
    input  logic [RES_W-1:0]  cnv_result,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        seq_state_e            state;
        logic [NUM_CH-1:0]     sel;
        logic [2*NUM_CH-1:0]   pre;
        logic [NUM_CH-1:0]     rem;
        logic [CH_W-1:0]       chan;
        logic                  done;
    } seq_regs_t;

    seq_regs_t cur_q, nx_d;
    logic      pre_en, wr_en;
    logic [CH_W-1:0] pick_idx;
    logic      pick_any;
    logic [NUM_CH-1:0] below_m;

    cnvseq_pick #(.NUM_CH(NUM_CH)) u_pick (
        .mask (cur_q.rem),
        .idx  (pick_idx),
        .any  (pick_any)
    );

    cnvseq_page #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_en    (pre_en),
        .pre_mask  (cur_q.sel),
        .pre_codes (cur_q.pre),
        .wr_en     (wr_en),
        .wr_ch     (cur_q.chan),
        .wr_data   (cnv_result),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    always_comb begin
        nx_d      = cur_q;
        nx_d.done = 1'b0;
        pre_en    = 1'b0;
        wr_en     = 1'b0;
        case (cur_q.state)
            ST_IDLE: begin
                if (byte_valid && byte_data == CMD_CONVERT) nx_d.state = ST_SEL;
            end
            ST_SEL: begin
                if (byte_valid) begin
                    nx_d.sel   = byte_data[NUM_CH-1:0];
                    nx_d.state = ST_PRE;
                end
            end
            ST_PRE: begin
                if (byte_valid) begin
                    nx_d.pre   = byte_data[2*NUM_CH-1:0];
                    nx_d.rem   = cur_q.sel;
                    nx_d.state = ST_PRESET;
                end
            end
            ST_PRESET: begin
                pre_en = 1'b1;
                if (cur_q.rem == '0) begin
                    nx_d.state = ST_IDLE;
                    nx_d.done  = 1'b1;
                end else begin
                    nx_d.state = ST_START;
                end
            end
            ST_START: begin
                nx_d.chan  = pick_idx;
                nx_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (cnv_done) begin
                    wr_en = 1'b1;
                    nx_d.rem[cur_q.chan] = 1'b0;
                    if (nx_d.rem == '0) begin
                        nx_d.state = ST_IDLE;
                        nx_d.done  = 1'b1;
                    end else begin
                        nx_d.state = ST_START;
                    end
                end
            end
            default: nx_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, default: '0};
        end else begin
            cur_q <= nx_d;
        end
    end

    assign cnv_start = (cur_q.state == ST_START) && pick_any;
    assign cnv_chan  = pick_idx;
    assign busy      = (cur_q.state == ST_PRESET) || (cur_q.state == ST_START)
                    || (cur_q.state == ST_WAIT);
    assign done      = cur_q.done;

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) below_m[i] = (CH_W'(i) < cnv_chan);
    end

    // R3
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |-> (cur_q.rem[cnv_chan] && ((cur_q.rem & below_m) == '0)));
    // R3
    single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> !cnv_start);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R10
    empty_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_PRESET && cur_q.rem == '0) |=> (done && !busy));
    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && byte_valid) |=> ($stable(cur_q.sel) && $stable(cur_q.pre)));
endmodule

// File: tb/tb_cnvseq_top.sv
`timescale 1ns/1ps
module tb_cnvseq_top;
    localparam int NUM_CH = 4;
    localparam int RES_W  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        cnv_start;
    logic [1:0]  cnv_chan;
    logic        cnv_done = 1'b0;
    logic [15:0] cnv_result = '0;
    logic        busy, done;

    always #2 clk = ~clk;

    cnvseq_top #(.NUM_CH(NUM_CH), .RES_W(RES_W)) dut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cnv_start(cnv_start),
        .cnv_chan(cnv_chan), .cnv_done(cnv_done), .cnv_result(cnv_result),
        .busy(busy), .done(done)
    );

    int          checks = 0;
    int          errors = 0;
    int          conv_lat = 2;
    logic [7:0]  conv_tag = '0;
    bit          stray_req = 1'b0;
    int          starts_seen = 0;
    bit          inflight = 1'b0;
    logic [15:0] exp_page [NUM_CH];
    int          exp_q [$];

    function automatic logic [15:0] conv_value(logic [7:0] tag, int ch);
        return {tag, 4'hA, 4'(ch)};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // converter model with programmable latency
    initial begin
        forever begin
            @(negedge clk);
            cnv_done = 1'b0;
            if (cnv_start) begin
                automatic int ch = int'(cnv_chan);
                repeat (conv_lat - 1) @(negedge clk);
                cnv_result = conv_value(conv_tag, ch);
                cnv_done   = 1'b1;
            end else if (stray_req) begin
                stray_req  = 1'b0;
                cnv_result = 16'h1234;
                cnv_done   = 1'b1;
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && cnv_start) begin
                starts_seen++;
                inflight = 1'b1;
                if (exp_q.size() == 0) begin
                    check("R3", "unexpected start channel", 32'(cnv_chan), 32'hFFFF_FFFF);
                end else begin
                    automatic int e = exp_q.pop_front();
                    check("R3", "start order", 32'(cnv_chan), 32'(e));
                    check("R9", "busy during start", 32'(busy), 32'd1);
                end
            end
            if (rst_n && cnv_done && inflight) begin
                inflight = 1'b0;
                check("R9", "busy at result strobe", 32'(busy), 32'd1);
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        byte_data  = b;
        byte_valid = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic read_word(input int ch, output logic [15:0] w);
        rd_addr = 3'(2 * ch);
        #0.2;
        w[7:0] = rd_data;
        rd_addr = 3'(2 * ch + 1);
        #0.2;
        w[15:8] = rd_data;
    endtask

    task automatic check_page(input string req, input string what);
        logic [15:0] w;
        for (int i = 0; i < NUM_CH; i++) begin
            read_word(i, w);
            check(req, $sformatf("%s ch%0d", what, i), 32'(w), 32'(exp_page[i]));
        end
    endtask

    task automatic do_convert(input logic [3:0] sel, input logic [7:0] pre,
                              input logic [7:0] tag);
        logic [15:0] pre_img [NUM_CH];
        logic [15:0] w;
        int wait_cnt;
        bit gap;
        conv_tag = tag;
        for (int i = 0; i < NUM_CH; i++) begin
            pre_img[i] = exp_page[i];
            if (sel[i]) begin
                if (pre[2*i +: 2] == 2'b01) pre_img[i] = 16'h0000;
                else if (pre[2*i +: 2] == 2'b10) pre_img[i] = 16'hFFFF;
                exp_q.push_back(i);
            end
        end
        send_byte(8'h3C);
        send_byte({4'h0, sel});
        send_byte(pre);
        check("R1", "busy after preset byte", 32'(busy), 32'd1);
        @(negedge clk);
        if (sel == 4'd0) begin
            check("R10", "done after empty select", 32'(done), 32'd1);
            check("R10", "busy after empty select", 32'(busy), 32'd0);
            check_page("R10", "unchanged");
        end else begin
            // presets visible before any result lands
            for (int i = 0; i < NUM_CH; i++) begin
                read_word(i, w);
                check(sel[i] ? "R4/R5/R6" : "R6",
                      $sformatf("preset image ch%0d", i), 32'(w), 32'(pre_img[i]));
            end
            wait_cnt = 0;
            gap = 1'b0;
            while (!done && wait_cnt < 500) begin
                if (!busy) gap = 1'b1;
                @(negedge clk);
                wait_cnt++;
            end
            check("R9", "done reached", 32'(done), 32'd1);
            check("R9", "busy gap before done", 32'(gap), 32'd0);
            check("R9", "busy low with done", 32'(busy), 32'd0);
            for (int i = 0; i < NUM_CH; i++)
                if (sel[i]) exp_page[i] = conv_value(tag, i);
            check_page("R7", "stored result");
            check("R2/R3", "all selected channels started", 32'(exp_q.size()), 32'd0);
            @(negedge clk);
            check("R9", "done one cycle", 32'(done), 32'd0);
        end
        repeat (2) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int s0;
        for (int i = 0; i < NUM_CH; i++) exp_page[i] = 16'h0000;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8", "busy in reset", 32'(busy), 32'd0);
        check("R8", "done in reset", 32'(done), 32'd0);
        check("R8", "start in reset", 32'(cnv_start), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_page("R8", "cleared page");

        // all channels, keep presets, short latency
        conv_lat = 2;
        do_convert(4'b1111, 8'h00, 8'h11);

        // B and D with zero/ones presets; A and C presets must be ignored
        conv_lat = 6;
        do_convert(4'b1010, 8'hA6, 8'h22);

        // A with invalid code 11, C cleared
        do_convert(4'b0101, 8'h13, 8'h33);

        // R10 empty select
        s0 = starts_seen;
        do_convert(4'b0000, 8'h55, 8'h44);
        check("R10", "no start for empty select", 32'(starts_seen), 32'(s0));

        // R1 non-command bytes and R7 stray strobe while idle
        s0 = starts_seen;
        send_byte(8'h55);
        send_byte(8'h0F);
        send_byte(8'h00);
        stray_req = 1'b1;
        repeat (6) @(negedge clk);
        check("R1", "no busy after non-command bytes", 32'(busy), 32'd0);
        check("R1", "no start after non-command bytes", 32'(starts_seen), 32'(s0));
        check_page("R7", "stray strobe ignored");

        // R11 bytes during busy ignored
        fork
            do_convert(4'b1000, 8'h00, 8'h55);
            begin
                wait (busy === 1'b1);
                @(negedge clk);
                send_byte(8'h3C);
                send_byte(8'h01);
                send_byte(8'h00);
            end
        join
        s0 = starts_seen;
        repeat (10) @(negedge clk);
        check("R11", "no batch from bytes sent while busy", 32'(starts_seen), 32'(s0));
        check("R11", "idle after ignored bytes", 32'(busy), 32'd0);

        // single middle channel, short latency
        conv_lat = 2;
        do_convert(4'b0100, 8'h20, 8'h66);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule